// File: doc/BRIEF.md
# Paged DMA Address Translation Unit

This block turns the addresses that a DMA-capable device issues into system memory addresses. It holds a local table of translation entries, one per I/O page. Each entry carries a page-aligned system address in its upper bits and a two-bit access code in bits [1:0]. A lookup request presents a window-relative I/O address. One clock later the block answers with four values: the page-aligned I/O address, the translated page address, the in-page offset mask and the access code.

A configuration port turns the window on and off as a whole. Turning it on loads a page shift, an entry count and a bus offset. Turning it off clears all three and wipes the table. A separate write port fills entries. It takes bus addresses, so the bus offset is subtracted before the page index is taken. The block also reports the size of its mapped window.

Top module: `dma_xlate_unit`

## Requirements
- R1: A lookup request is answered by `rsp_valid` high exactly one clock later. `rsp_valid` is low in any cycle that does not follow a request.
- R2: For an address whose page index (address shifted right by the current shift) is below the entry count, the page mask is the inverse of (2^shift − 1). `rsp_iova` is the address ANDed with that mask. `rsp_xaddr` is the entry ANDed with that mask. `rsp_mask` is the inverse of the page mask.
- R3: `rsp_perm` is entry bits [1:0]: 0 is no access, 1 is read-only, 2 is write-only and 3 is read-write.
- R4: A lookup whose index is at or above the entry count returns `rsp_iova` = 0, `rsp_xaddr` = 0, an all-ones `rsp_mask` and `rsp_perm` = 0. This includes every lookup while the window is off (count 0).
- R5: After reset the entry count, shift and offset are zero and every table entry is zero, so every page reports no access once the window is enabled.
- R6: An enable request takes effect only if the current count is zero, the requested shift lies in [SHIFT_MIN, SHIFT_MAX] and the requested count lies in [1, DEPTH]. Any other enable request changes nothing.
- R7: A disable request clears the count, shift and offset to zero and zeroes every table entry. If a disable and an enable arrive in the same cycle, the disable wins.
- R8: `win_size` equals the entry count shifted left by the shift.
- R9: A table write selects entry ((`tw_addr` − offset) mod 2^AW) >> shift. The write is stored only if that index is below the count, and it is visible to lookups from the next cycle on. Any other write is dropped.
- R10: A lookup issued in the same cycle as a write to the same entry returns the entry's old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Request to turn the window on with the values below |
| cfg_disable | input | 1 | Request to turn the window off and wipe the table |
| cfg_shift | input | SW | Requested page shift |
| cfg_count | input | CW | Requested number of entries |
| cfg_offset | input | AW | Requested bus offset for table writes |
| tw_en | input | 1 | Table write strobe |
| tw_addr | input | AW | Bus address that selects the entry to write |
| tw_data | input | AW | Entry value: page address plus access code in [1:0] |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | AW | Window-relative I/O address to translate |
| rsp_valid | output | 1 | Response strobe, one clock after `lk_req` |
| rsp_iova | output | AW | Page-aligned I/O address |
| rsp_xaddr | output | AW | Translated page address |
| rsp_mask | output | AW | In-page offset mask |
| rsp_perm | output | 2 | Access code |
| win_size | output | AW | Mapped window size in bytes |

## Verification
The bench uses the default build: 32-bit addresses, 16 entries and shifts from 12 to 24. With these values a full table at the largest shift still fits the address width. Random enables can therefore reach every legal shift, and they can also hit the last entry, the first index past the count and offsets large enough to wrap the write subtraction. Rejected enables are driven with shift 11, shift 25, count 0 and count 17. These show that the range limits are enforced at both ends.

// File: rtl/dxu_pkg.sv
package dxu_pkg;

    localparam int PERM_W = 2;

    typedef enum logic [PERM_W-1:0] {
        PERM_NONE = 2'd0,
        PERM_RO   = 2'd1,
        PERM_WO   = 2'd2,
        PERM_RW   = 2'd3
    } dxu_perm_e;

    // Access code carried in the two least significant bits of an entry.
    function automatic dxu_perm_e perm_decode(input logic [PERM_W-1:0] bits);
        dxu_perm_e p;
        case (bits)
            2'd1:    p = PERM_RO;
            2'd2:    p = PERM_WO;
            2'd3:    p = PERM_RW;
            default: p = PERM_NONE;
        endcase
        return p;
    endfunction

    function automatic int idx_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/dxu_config.sv
module dxu_config #(
    parameter int AW        = 32,
    parameter int DEPTH     = 16,
    parameter int SHIFT_MIN = 12,
    parameter int SHIFT_MAX = 24,
    parameter int SW        = $clog2(SHIFT_MAX + 1),
    parameter int CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_req,
    input  logic          dis_req,
    input  logic [SW-1:0] req_shift,
    input  logic [CW-1:0] req_count,
    input  logic [AW-1:0] req_offset,
    output logic [SW-1:0] cur_shift,
    output logic [CW-1:0] cur_count,
    output logic [AW-1:0] cur_offset,
    output logic          clear_tbl,
    output logic [AW-1:0] win_size
);

    logic req_legal;
    logic load;

    always_comb begin
        req_legal = (req_shift >= SW'(SHIFT_MIN)) && (req_shift <= SW'(SHIFT_MAX)) &&
                    (req_count != '0) && (req_count <= CW'(DEPTH));
        load      = en_req && !dis_req && (cur_count == '0) && req_legal;
        clear_tbl = dis_req;
        win_size  = AW'(cur_count) << cur_shift;
    end

    always_ff @(posedge clk) begin
        if (rst || dis_req) begin
            cur_shift  <= '0;
            cur_count  <= '0;
            cur_offset <= '0;
        end else if (load) begin
            cur_shift  <= req_shift;
            cur_count  <= req_count;
            cur_offset <= req_offset;
        end
    end

endmodule

// File: rtl/dxu_table.sv
module dxu_table #(
    parameter int AW    = 32,
    parameter int DEPTH = 16,
    parameter int IW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_data
);

    logic [DEPTH-1:0][AW-1:0] ent;

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst || clear) begin
                ent[i] <= '0;
            end else if (wr_en && (wr_idx == IW'(i))) begin
                ent[i] <= wr_data;
            end
        end
    end

    generate
        if ((1 << IW) == DEPTH) begin : g_pow2
            assign rd_data = ent[rd_idx];
        end else begin : g_guard
            always_comb begin
                rd_data = '0;
                for (int i = 0; i < DEPTH; i++) begin
                    if (rd_idx == IW'(i)) rd_data = ent[i];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/dxu_lookup.sv
module dxu_lookup
    import dxu_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 5,
    parameter int CW = 5,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lk_req,
    input  logic [AW-1:0] lk_addr,
    input  logic [SW-1:0] cur_shift,
    input  logic [CW-1:0] cur_count,
    output logic [IW-1:0] rd_idx,
    input  logic [AW-1:0] rd_data,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_iova,
    output logic [AW-1:0] rsp_xaddr,
    output logic [AW-1:0] rsp_mask,
    output dxu_perm_e     rsp_perm
);

    typedef struct packed {
        logic [AW-1:0] iova;
        logic [AW-1:0] xaddr;
        logic [AW-1:0] mask;
        dxu_perm_e     perm;
    } rsp_t;

    logic [AW-1:0] idx_full;
    logic [AW-1:0] page_mask;
    logic          in_win;
    rsp_t          nxt;
    rsp_t          cur;

    always_comb begin
        idx_full  = lk_addr >> cur_shift;
        page_mask = ~((AW'(1) << cur_shift) - AW'(1));
        in_win    = (cur_count != '0) && (idx_full < AW'(cur_count));
        rd_idx    = idx_full[IW-1:0];
        if (in_win) begin
            nxt.iova  = lk_addr & page_mask;
            nxt.xaddr = rd_data & page_mask;
            nxt.mask  = ~page_mask;
            nxt.perm  = perm_decode(rd_data[PERM_W-1:0]);
        end else begin
            nxt.iova  = '0;
            nxt.xaddr = '0;
            nxt.mask  = '1;
            nxt.perm  = PERM_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            cur.iova   <= '0;
            cur.xaddr  <= '0;
            cur.mask   <= '1;
            cur.perm   <= PERM_NONE;
        end else begin
            rsp_valid <= lk_req;
            if (lk_req) cur <= nxt;
        end
    end

    assign rsp_iova  = cur.iova;
    assign rsp_xaddr = cur.xaddr;
    assign rsp_mask  = cur.mask;
    assign rsp_perm  = cur.perm;

endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit
    import dxu_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DEPTH     = 16,
    parameter int SHIFT_MIN = 12,
    parameter int SHIFT_MAX = 24,
    parameter int SW        = $clog2(SHIFT_MAX + 1),
    parameter int CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_enable,
    input  logic          cfg_disable,
    input  logic [SW-1:0] cfg_shift,
    input  logic [CW-1:0] cfg_count,
    input  logic [AW-1:0] cfg_offset,
    input  logic          tw_en,
    input  logic [AW-1:0] tw_addr,
    input  logic [AW-1:0] tw_data,
    input  logic          lk_req,
    input  logic [AW-1:0] lk_addr,
    output logic          rsp_valid,
    output logic [AW-1:0] rsp_iova,
    output logic [AW-1:0] rsp_xaddr,
    output logic [AW-1:0] rsp_mask,
    output logic [1:0]    rsp_perm,
    output logic [AW-1:0] win_size
);

    localparam int IW = idx_width(DEPTH);

    logic [SW-1:0] cur_shift;
    logic [CW-1:0] cur_count;
    logic [AW-1:0] cur_offset;
    logic          clear_tbl;
    logic [AW-1:0] wr_rel;
    logic [AW-1:0] wr_idx_full;
    logic          wr_hit;
    logic [IW-1:0] rd_idx;
    logic [AW-1:0] rd_data;
    dxu_perm_e     perm_q;

    dxu_config #(
        .AW(AW), .DEPTH(DEPTH), .SHIFT_MIN(SHIFT_MIN), .SHIFT_MAX(SHIFT_MAX),
        .SW(SW), .CW(CW)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .en_req    (cfg_enable),
        .dis_req   (cfg_disable),
        .req_shift (cfg_shift),
        .req_count (cfg_count),
        .req_offset(cfg_offset),
        .cur_shift (cur_shift),
        .cur_count (cur_count),
        .cur_offset(cur_offset),
        .clear_tbl (clear_tbl),
        .win_size  (win_size)
    );

    // Write side: bus address relative to the offset, modulo 2^AW.
    always_comb begin
        wr_rel      = tw_addr - cur_offset;
        wr_idx_full = wr_rel >> cur_shift;
        wr_hit      = tw_en && (cur_count != '0) && (wr_idx_full < AW'(cur_count));
    end

    dxu_table #(.AW(AW), .DEPTH(DEPTH), .IW(IW)) u_tbl (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear_tbl),
        .wr_en  (wr_hit),
        .wr_idx (wr_idx_full[IW-1:0]),
        .wr_data(tw_data),
        .rd_idx (rd_idx),
        .rd_data(rd_data)
    );

    dxu_lookup #(.AW(AW), .SW(SW), .CW(CW), .IW(IW)) u_lk (
        .clk      (clk),
        .rst      (rst),
        .lk_req   (lk_req),
        .lk_addr  (lk_addr),
        .cur_shift(cur_shift),
        .cur_count(cur_count),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .rsp_valid(rsp_valid),
        .rsp_iova (rsp_iova),
        .rsp_xaddr(rsp_xaddr),
        .rsp_mask (rsp_mask),
        .rsp_perm (perm_q)
    );

    assign rsp_perm = perm_q;

endmodule

// File: rtl/dxu_checker.sv
module dxu_checker #(
    parameter int AW        = 32,
    parameter int DEPTH     = 16,
    parameter int SHIFT_MIN = 12,
    parameter int SHIFT_MAX = 24,
    parameter int SW        = 5,
    parameter int CW        = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_enable,
    input logic          cfg_disable,
    input logic          lk_req,
    input logic          rsp_valid,
    input logic [AW-1:0] rsp_iova,
    input logic [AW-1:0] rsp_xaddr,
    input logic [AW-1:0] rsp_mask,
    input logic [1:0]    rsp_perm,
    input logic [SW-1:0] cur_shift,
    input logic [CW-1:0] cur_count,
    input logic [AW-1:0] cur_offset
);

    a_r1_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> rsp_valid);

    a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !rsp_valid);

    a_r2_mask_disjoint: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (((rsp_iova & rsp_mask) == '0) && ((rsp_xaddr & rsp_mask) == '0)));

    a_r4_outside_no_access: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (&rsp_mask)) |-> ((rsp_perm == 2'd0) && (rsp_iova == '0) && (rsp_xaddr == '0)));

    a_r6_enable_ignored: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable && !cfg_disable && (cur_count != '0)) |=>
            ($stable(cur_count) && $stable(cur_shift) && $stable(cur_offset)));

    a_r6_config_in_range: assert property (@(posedge clk) disable iff (rst)
        (cur_count != '0) |-> ((cur_shift >= SW'(SHIFT_MIN)) && (cur_shift <= SW'(SHIFT_MAX)) &&
                               (cur_count <= CW'(DEPTH))));

    a_r7_disable_clears: assert property (@(posedge clk) disable iff (rst)
        cfg_disable |=> ((cur_count == '0) && (cur_shift == '0) && (cur_offset == '0)));

endmodule

bind dma_xlate_unit dxu_checker #(
    .AW(AW), .DEPTH(DEPTH), .SHIFT_MIN(SHIFT_MIN), .SHIFT_MAX(SHIFT_MAX), .SW(SW), .CW(CW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_enable (cfg_enable),
    .cfg_disable(cfg_disable),
    .lk_req     (lk_req),
    .rsp_valid  (rsp_valid),
    .rsp_iova   (rsp_iova),
    .rsp_xaddr  (rsp_xaddr),
    .rsp_mask   (rsp_mask),
    .rsp_perm   (rsp_perm),
    .cur_shift  (cur_shift),
    .cur_count  (cur_count),
    .cur_offset (cur_offset)
);

// File: tb/dma_xlate_unit_tb.sv
module dma_xlate_unit_tb;

    localparam int AW = 32;
    localparam int DEPTH = 16;
    localparam int SMIN = 12;
    localparam int SMAX = 24;
    localparam int SW = $clog2(SMAX + 1);
    localparam int CW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_enable = 1'b0, cfg_disable = 1'b0;
    logic [SW-1:0] cfg_shift = '0;
    logic [CW-1:0] cfg_count = '0;
    logic [AW-1:0] cfg_offset = '0;
    logic          tw_en = 1'b0;
    logic [AW-1:0] tw_addr = '0, tw_data = '0;
    logic          lk_req = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          rsp_valid;
    logic [AW-1:0] rsp_iova, rsp_xaddr, rsp_mask, win_size;
    logic [1:0]    rsp_perm;

    dma_xlate_unit #(.AW(AW), .DEPTH(DEPTH), .SHIFT_MIN(SMIN), .SHIFT_MAX(SMAX)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_enable(cfg_enable), .cfg_disable(cfg_disable), .cfg_shift(cfg_shift),
        .cfg_count(cfg_count), .cfg_offset(cfg_offset),
        .tw_en(tw_en), .tw_addr(tw_addr), .tw_data(tw_data),
        .lk_req(lk_req), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_iova(rsp_iova), .rsp_xaddr(rsp_xaddr),
        .rsp_mask(rsp_mask), .rsp_perm(rsp_perm), .win_size(win_size)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 1'b0;

    // Reference state kept by the bench.
    logic [AW-1:0] m_tbl [DEPTH];
    int            m_shift = 0;
    int            m_count = 0;
    logic [AW-1:0] m_off = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic model_lookup(input logic [AW-1:0] a, output logic [AW-1:0] e_iova,
                                output logic [AW-1:0] e_x, output logic [AW-1:0] e_mask,
                                output logic [1:0] e_perm);
        logic [AW-1:0] pm;
        logic [AW-1:0] idx;
        idx = a >> m_shift;
        if (m_count == 0 || idx >= AW'(m_count)) begin
            e_iova = '0; e_x = '0; e_mask = '1; e_perm = 2'd0;
        end else begin
            pm = ~((AW'(1) << m_shift) - AW'(1));
            e_iova = a & pm;
            e_x    = m_tbl[idx[3:0]] & pm;
            e_mask = ~pm;
            e_perm = m_tbl[idx[3:0]][1:0];
        end
    endtask

    // One cycle with an optional write and an optional lookup, checked next cycle.
    task automatic step(input bit dw, input logic [AW-1:0] wa, input logic [AW-1:0] wd,
                        input bit dl, input logic [AW-1:0] la, input string req);
        logic [AW-1:0] ei, ex, em, rel, idx;
        logic [1:0]    ep;
        tw_en = dw; tw_addr = wa; tw_data = wd;
        lk_req = dl; lk_addr = la;
        model_lookup(la, ei, ex, em, ep);
        if (dw && m_count != 0) begin
            rel = wa - m_off;
            idx = rel >> m_shift;
            if (idx < AW'(m_count)) m_tbl[idx[3:0]] = wd;
        end
        @(negedge clk);
        tw_en = 1'b0; lk_req = 1'b0;
        if (dl) begin
            chk(rsp_valid === 1'b1, "R1", "valid after request", AW'(rsp_valid), 1);
            chk(rsp_iova === ei, req, "iova", rsp_iova, ei);
            chk(rsp_xaddr === ex, req, "xaddr", rsp_xaddr, ex);
            chk(rsp_mask === em, req, "mask", rsp_mask, em);
            chk(rsp_perm === ep, "R3", "perm", AW'(rsp_perm), AW'(ep));
        end else begin
            chk(rsp_valid === 1'b0, "R1", "valid without request", AW'(rsp_valid), 0);
        end
    endtask

    task automatic cfg(input bit en, input bit dis, input int sh, input int cnt,
                       input logic [AW-1:0] off, input string req);
        cfg_enable = en; cfg_disable = dis;
        cfg_shift = SW'(sh); cfg_count = CW'(cnt); cfg_offset = off;
        if (dis) begin
            m_count = 0; m_shift = 0; m_off = '0;
            for (int i = 0; i < DEPTH; i++) m_tbl[i] = '0;
        end else if (en && m_count == 0 && sh >= SMIN && sh <= SMAX && cnt >= 1 && cnt <= DEPTH) begin
            m_count = cnt; m_shift = sh; m_off = off;
        end
        @(negedge clk);
        cfg_enable = 1'b0; cfg_disable = 1'b0;
        chk(win_size === (AW'(m_count) << m_shift), req, "window size",
            win_size, AW'(m_count) << m_shift);
    endtask

    function automatic logic [AW-1:0] page_addr(input int idx, input int low);
        return (AW'(idx) << m_shift) | (AW'(low) & ((AW'(1) << m_shift) - AW'(1)));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int i = 0; i < DEPTH; i++) m_tbl[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R5 / R4: reset state, window off.
        chk(rsp_valid === 1'b0, "R5", "valid at reset", AW'(rsp_valid), 0);
        chk(win_size === '0, "R5", "window at reset", win_size, 0);
        step(0, 0, 0, 1, 32'h0000_0000, "R4");
        step(0, 0, 0, 1, 32'h0000_3abc, "R4");
        step(0, 0, 0, 0, 0, "R1");

        // R6: illegal enables are ignored.
        cfg(1, 0, 11, 4, 0, "R6");
        cfg(1, 0, 25, 4, 0, "R6");
        cfg(1, 0, 12, 0, 0, "R6");
        cfg(1, 0, 12, 17, 0, "R6");

        // R5: fresh entries fault; R8 window size.
        cfg(1, 0, 12, 4, 32'h8000_0000, "R8");
        step(0, 0, 0, 1, 32'h0000_1234, "R5");
        // R9: write via offset, then R2/R3.
        step(1, 32'h8000_1000, 32'h1234_5003, 0, 0, "R9");
        step(0, 0, 0, 1, 32'h0000_1fff, "R2");
        step(1, 32'h8000_3fff, 32'hdead_b001, 0, 0, "R9");
        step(0, 0, 0, 1, 32'h0000_3000, "R3");
        // R9: below offset (wraps) and past count are dropped.
        step(1, 32'h7fff_f000, 32'hffff_f003, 0, 0, "R9");
        step(1, 32'h8000_4000, 32'hffff_f003, 0, 0, "R9");
        for (int p = 0; p < 5; p++) step(0, 0, 0, 1, page_addr(p, 12'h777), "R9");
        // R4: index equal to count.
        step(0, 0, 0, 1, 32'h0000_4000, "R4");
        // R10: same-cycle write and lookup of one entry.
        step(1, 32'h8000_1000, 32'h0bad_0002, 1, 32'h0000_1000, "R10");
        step(0, 0, 0, 1, 32'h0000_1000, "R10");
        // R6: enable while on is ignored.
        cfg(1, 0, 20, 8, 32'h0, "R6");
        step(0, 0, 0, 1, 32'h0000_1004, "R6");
        // R7: disable wins over simultaneous enable and wipes the table.
        cfg(1, 1, 13, 2, 0, "R7");
        step(0, 0, 0, 1, 32'h0000_1000, "R7");
        cfg(1, 0, 12, 4, 32'h8000_0000, "R7");
        step(0, 0, 0, 1, 32'h0000_1000, "R7");

        // Random rounds.
        for (int r = 0; r < 12; r++) begin
            int sh, cnt;
            logic [AW-1:0] off;
            sh  = SMIN + int'($urandom_range(SMAX - SMIN));
            cnt = 1 + int'($urandom_range(DEPTH - 1));
            off = $urandom();
            cfg(0, 1, 0, 0, 0, "R7");
            cfg(1, 0, sh, cnt, off, "R8");
            for (int k = 0; k < 40; k++) begin
                int sel, wi, li;
                logic [AW-1:0] wa, la, wd;
                sel = int'($urandom_range(3));
                wi  = int'($urandom_range(cnt + 1));
                li  = (sel == 3) ? wi : int'($urandom_range(cnt + 1));
                wd  = $urandom();
                wa  = off + page_addr(wi, int'($urandom()));
                la  = page_addr(li, int'($urandom()));
                case (sel)
                    0: step(1, wa, wd, 0, 0, "R9");
                    1: step(0, 0, 0, 1, la, "R2");
                    2: step(1, wa, wd, 1, la, "R3");
                    default: step(1, wa, wd, 1, la, "R10");
                endcase
            end
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule